// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block decides when an on-chip logic analyzer should start capturing. A bank of comparators watches a probe bus. Each comparator can look for a masked value, or for a rising or falling edge on one selected probe bit. A small table of states defines what happens next. Each state holds three prioritised branches, and every branch pairs a condition with an action. The condition combines comparator results and can also require a counter to equal a value. The action can bump or clear counters, set or clear flags, pick the next state and fire the trigger.

Software loads the comparator settings and the branch table through a simple write port while the sequencer is disarmed, so a new trigger program needs no new hardware. Arming starts the program from state 0 with clean counters, flags and edge history. The first branch whose condition holds is taken on every clock cycle. A trigger emits one pulse, and the sequencer then freezes until it is disarmed.

Top module: `seq_trigger`

## Requirements
- R1: While reset is held and right after it: trig_o, armed_o and triggered_o are 0, state_o is 0, flags_o is 0, and every comparator and branch entry is all zeros.
- R2: A configuration write lands only while armed_o is 0; writes while armed change nothing. Address a < 4 selects comparator a. Address 4 + 3*s + b selects branch b (0..2) of state s. Higher addresses are ignored.
- R3: Raising arm_i while disarmed sets armed_o one cycle later. At the same time state_o and flags_o become 0, all counters become 0, and the previous-sample register used for edge detection is cleared to 0. A probe bit that is already high on the first armed cycle therefore counts as a rising edge.
- R4: In each armed, untriggered cycle, branches 0, 1 and 2 of the current state are tried in that order, using that cycle's probe values, and only the first true one acts. When none is true, the state, counters and flags keep their values.
- R5: The comparator word, from LSB, holds: value [7:0], mask [15:8], bit select [18:16] and mode [20:19]. Mode 0 never matches. Mode 1 matches when (probe XOR value) AND mask is zero. Mode 2 is a 0-to-1 change of the selected bit. Mode 3 is a 1-to-0 change.
- R6: The branch word, from LSB, holds: next state [2:0], trigger [3], flag clear [7:4], flag set [11:8], counter reset [15:12], counter increment [19:16], compare value [27:20], compare counter [29:28], compare enable [30], OR select [31] and comparator enable [35:32]. The comparator term is the AND (OR select 0) or the OR (select 1) of the enabled comparators, and it is true when none is enabled. The condition is this term ANDed with (compare disabled, or the selected counter equal to the compare value).
- R7: The four 8-bit counters saturate at 255. A reset bit wins over an increment bit for the same counter.
- R8: A taken branch forms the new flags as (flags OR set) AND NOT clear, so clear wins. The flags appear on flags_o.
- R9: A taken branch with the trigger bit makes trig_o 1 for exactly one cycle. Its counter and flag actions and its next state still apply. After that, triggered_o stays 1, and state_o and flags_o stay frozen while arm_i stays high.
- R10: Lowering arm_i makes armed_o, triggered_o and trig_o 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Level: high runs the trigger program, low disarms |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Comparator or branch entry address |
| cfg_wdata_i | input | 36 | Comparator or branch word |
| probe_i | input | 8 | Probe bus under observation |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | Sequencer running or triggered |
| triggered_o | output | 1 | Trigger has fired since arming |
| state_o | output | 3 | Current state index |
| flags_o | output | 4 | Debug flags |

## Verification
Three trigger programs are loaded in turn. The first counts rising edges and fires on the fourth while a probe bit is already high at arming. This separates a correctly cleared edge history and a winning compare-and-reset branch from an off-by-one count. The second walks a falling value sequence with a retry branch, an abort branch and a branch that matches nothing. It then fires either on a value match or on a rising edge through an OR, which shows the branch priority, the set/clear flag arithmetic and that writes made while armed are ignored. The third pairs an AND of two bits and a never-matching comparator with a counter driven past 255 and a same-cycle reset plus increment, which catches wrap-around and the wrong winner between reset and increment.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int PROBE_W = 8,
  parameter int N_CMP   = 4,
  parameter int N_STATE = 8,
  parameter int N_CNT   = 4,
  parameter int CNT_W   = 8,
  parameter int N_FLAG  = 4,
  localparam int N_BR    = 3,
  localparam int STATE_W = $clog2(N_STATE),
  localparam int SEL_W   = $clog2(PROBE_W),
  localparam int CSEL_W  = $clog2(N_CNT),
  localparam int O_TRIG  = STATE_W,
  localparam int O_FCLR  = O_TRIG + 1,
  localparam int O_FSET  = O_FCLR + N_FLAG,
  localparam int O_CRST  = O_FSET + N_FLAG,
  localparam int O_CINC  = O_CRST + N_CNT,
  localparam int O_CVAL  = O_CINC + N_CNT,
  localparam int O_CSEL  = O_CVAL + CNT_W,
  localparam int O_CEN   = O_CSEL + CSEL_W,
  localparam int O_OR    = O_CEN + 1,
  localparam int O_EN    = O_OR + 1,
  localparam int BR_W    = O_EN + N_CMP,
  localparam int C_MASK  = PROBE_W,
  localparam int C_BIT   = 2 * PROBE_W,
  localparam int C_MODE  = C_BIT + SEL_W,
  localparam int CMP_W   = C_MODE + 2,
  localparam int CFG_W   = (BR_W > CMP_W) ? BR_W : CMP_W,
  localparam int N_ENT   = N_CMP + N_STATE * N_BR,
  localparam int ADDR_W  = $clog2(N_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [PROBE_W-1:0] probe_i,
  output logic               trig_o,
  output logic               armed_o,
  output logic               triggered_o,
  output logic [STATE_W-1:0] state_o,
  output logic [N_FLAG-1:0]  flags_o
);

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_t;

  phase_t               phase_q;
  logic [STATE_W-1:0]   state_q;
  logic [N_FLAG-1:0]    flags_q;
  logic [PROBE_W-1:0]   prev_q;
  logic                 trig_q;
  logic [CNT_W-1:0]     cnt_q [N_CNT];
  logic [CMP_W-1:0]     cmp_cfg [N_CMP];
  logic [BR_W-1:0]      br_cfg [N_STATE*N_BR];

  logic [N_CMP-1:0]     hit;
  logic [BR_W-1:0]      cur_br [N_BR];
  logic [N_BR-1:0]      cond;
  logic                 take;
  logic [BR_W-1:0]      act;

  wire cfg_open = (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CMP; i++) cmp_cfg[i] <= '0;
      for (int i = 0; i < N_STATE*N_BR; i++) br_cfg[i] <= '0;
    end else if (cfg_we_i && cfg_open) begin
      for (int i = 0; i < N_CMP; i++)
        if (cfg_addr_i == ADDR_W'(i)) cmp_cfg[i] <= cfg_wdata_i[CMP_W-1:0];
      for (int i = 0; i < N_STATE*N_BR; i++)
        if (cfg_addr_i == ADDR_W'(N_CMP + i)) br_cfg[i] <= cfg_wdata_i[BR_W-1:0];
    end
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    wire [1:0]         mode = cmp_cfg[g][C_MODE +: 2];
    wire [SEL_W-1:0]   bsel = cmp_cfg[g][C_BIT +: SEL_W];
    wire [PROBE_W-1:0] mval = cmp_cfg[g][0 +: PROBE_W];
    wire [PROBE_W-1:0] mmsk = cmp_cfg[g][C_MASK +: PROBE_W];
    wire               cur  = probe_i[bsel];
    wire               old  = prev_q[bsel];
    always_comb begin
      case (mode)
        2'd1:    hit[g] = (((probe_i ^ mval) & mmsk) == '0);
        2'd2:    hit[g] = cur & ~old;
        2'd3:    hit[g] = ~cur & old;
        default: hit[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    take = 1'b0;
    act  = '0;
    for (int b = 0; b < N_BR; b++) begin
      logic [N_CMP-1:0]  en;
      logic [CSEL_W-1:0] csel;
      logic              cmp_ok, cnt_ok;
      cur_br[b] = br_cfg[int'(state_q) * N_BR + b];
      en        = cur_br[b][O_EN +: N_CMP];
      csel      = cur_br[b][O_CSEL +: CSEL_W];
      if (en == '0)            cmp_ok = 1'b1;
      else if (cur_br[b][O_OR]) cmp_ok = |(hit & en);
      else                     cmp_ok = &(hit | ~en);
      cnt_ok  = !cur_br[b][O_CEN] || (cnt_q[csel] == cur_br[b][O_CVAL +: CNT_W]);
      cond[b] = cmp_ok && cnt_ok;
      if (!take && cond[b]) begin
        take = 1'b1;
        act  = cur_br[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      state_q <= '0;
      flags_q <= '0;
      prev_q  <= '0;
      trig_q  <= 1'b0;
      for (int c = 0; c < N_CNT; c++) cnt_q[c] <= '0;
    end else begin
      trig_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (arm_i) begin
          phase_q <= PH_RUN;
          state_q <= '0;
          flags_q <= '0;
          prev_q  <= '0;
          for (int c = 0; c < N_CNT; c++) cnt_q[c] <= '0;
        end
        PH_RUN: if (!arm_i) begin
          phase_q <= PH_IDLE;
        end else begin
          prev_q <= probe_i;
          if (take) begin
            state_q <= act[0 +: STATE_W];
            flags_q <= (flags_q | act[O_FSET +: N_FLAG]) & ~act[O_FCLR +: N_FLAG];
            for (int c = 0; c < N_CNT; c++) begin
              if (act[O_CRST + c])                        cnt_q[c] <= '0;
              else if (act[O_CINC + c] && cnt_q[c] != '1) cnt_q[c] <= cnt_q[c] + 1'b1;
            end
            if (act[O_TRIG]) begin
              trig_q  <= 1'b1;
              phase_q <= PH_DONE;
            end
          end
        end
        default: if (!arm_i) phase_q <= PH_IDLE;
      endcase
    end
  end

  assign trig_o      = trig_q;
  assign armed_o     = (phase_q != PH_IDLE);
  assign triggered_o = (phase_q == PH_DONE);
  assign state_o     = state_q;
  assign flags_o     = flags_q;

endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk #(
  parameter int N_FLAG  = 4,
  parameter int STATE_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arm_i,
  input logic               trig_o,
  input logic               armed_o,
  input logic               triggered_o,
  input logic [STATE_W-1:0] state_o,
  input logic [N_FLAG-1:0]  flags_o
);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r9_pulse_marks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (triggered_o && armed_o));

  a_r9_done_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && arm_i) |=> (triggered_o && $stable(state_o) && $stable(flags_o)));

  a_r3_arm_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> (state_o == '0 && flags_o == '0 && !triggered_o && !trig_o));

  a_r10_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (!armed_o && !triggered_o && !trig_o));

endmodule

bind seq_trigger seq_trigger_chk #(.N_FLAG(N_FLAG), .STATE_W(STATE_W)) u_chk (.*);

// File: tb/seq_trigger_tb.sv
module seq_trigger_tb_top;

  localparam int CFG_W = 36;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             arm;
  logic             cfg_we;
  logic [4:0]       cfg_addr;
  logic [CFG_W-1:0] cfg_wdata;
  logic [7:0]       probe;
  logic             trig_o, armed_o, triggered_o;
  logic [2:0]       state_o;
  logic [3:0]       flags_o;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] st;
    logic [3:0] fl;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  seq_trigger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .probe_i(probe),
    .trig_o(trig_o), .armed_o(armed_o), .triggered_o(triggered_o),
    .state_o(state_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  function automatic logic [CFG_W-1:0] br(
      input logic [3:0] en, input logic orr, input logic cen, input logic [1:0] csel,
      input logic [7:0] cval, input logic [3:0] cinc, input logic [3:0] crst,
      input logic [3:0] fset, input logic [3:0] fclr, input logic trig, input logic [2:0] nxt);
    return {en, orr, cen, csel, cval, cinc, crst, fset, fclr, trig, nxt};
  endfunction

  function automatic logic [CFG_W-1:0] cmpw(input logic [1:0] mode, input logic [2:0] bsel,
                                            input logic [7:0] mask, input logic [7:0] val);
    return CFG_W'({mode, bsel, mask, val});
  endfunction

  function automatic logic [4:0] ba(input int s, input int b);
    return 5'(4 + 3 * s + b);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [CFG_W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 28; i++) wr(5'(i), '0);
  endtask

  task automatic put(input logic [7:0] p);
    probe = p;
    @(negedge clk);
  endtask

  task automatic arm_on();
    arm = 1'b1;
    @(negedge clk);
    chk("R3 armed after arm", armed_o, 1);
    chk("R3 state cleared", state_o, 0);
    chk("R3 flags cleared", flags_o, 0);
  endtask

  task automatic arm_off();
    arm = 1'b0;
    @(negedge clk);
    chk("R10 disarmed", armed_o, 0);
    chk("R10 triggered cleared", triggered_o, 0);
  endtask

  task automatic expect_trig(input logic [2:0] st, input logic [3:0] fl, input string req);
    exp_t e;
    e.st = st; e.fl = fl; e.req = req;
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && trig_o) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_err++;
        $display("FAIL R9 unexpected trigger actual=1 expected=0 (state %0d)", state_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (state_o !== e.st || flags_o !== e.fl || triggered_o !== 1'b1) begin
          n_err++;
          $display("FAIL %s actual=st%0d/fl%0h/done%0b expected=st%0d/fl%0h/done1",
                   e.req, state_o, flags_o, triggered_o, e.st, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; probe = '0;
    repeat (3) @(negedge clk);
    chk("R1 trig_o in reset", trig_o, 0);
    chk("R1 armed_o in reset", armed_o, 0);
    chk("R1 triggered_o in reset", triggered_o, 0);
    chk("R1 state/flags in reset", {state_o, flags_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Program A: fire on fourth rising edge of bit 0 (R5 mode 2, R6 compare, R7, R9)
    wr(5'd0, cmpw(2'd2, 3'd0, 8'h00, 8'h00));
    wr(ba(0,0), br(4'b0001, 0, 1, 2'd0, 8'd3, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 1, 3'd0));
    wr(ba(0,1), br(4'b0001, 0, 0, 2'd0, 8'd0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 0, 3'd0));
    put(8'h01);
    arm_on();
    put(8'h01);
    chk("R3 first-cycle edge no trigger", trig_o, 0);
    put(8'h00); put(8'h01); put(8'h00); put(8'h01); put(8'h00);
    chk("R4 third edge not triggered", triggered_o, 0);
    expect_trig(3'd0, 4'b0001, "R9 fourth edge trigger");
    put(8'h01);
    chk("R9 triggered after fourth edge", triggered_o, 1);
    put(8'h00); put(8'h01); put(8'h00);
    chk("R9 triggered holds", triggered_o, 1);
    chk("R9 flags frozen", flags_o, 4'b0001);
    arm_off();

    // Program B: sequence 7,6 then 5 or rise of bit 7 (R2, R4, R5, R6, R8)
    clear_all();
    wr(5'd0, cmpw(2'd1, 3'd0, 8'hFF, 8'h07));
    wr(5'd1, cmpw(2'd1, 3'd0, 8'hFF, 8'h06));
    wr(5'd2, cmpw(2'd1, 3'd0, 8'hFF, 8'h05));
    wr(5'd3, cmpw(2'd2, 3'd7, 8'h00, 8'h00));
    wr(ba(0,0), br(4'b0001, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 0, 3'd1));
    wr(ba(1,0), br(4'b0010, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 0, 3'd2));
    wr(ba(1,1), br(4'b0001, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 3'd1));
    wr(ba(1,2), br(4'b0000, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0001, 4'b0010, 0, 3'd0));
    wr(ba(2,0), br(4'b1100, 1, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0001, 4'b0100, 1, 3'd2));
    wr(ba(2,1), br(4'b0001, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 0, 3'd0));
    wr(ba(2,2), br(4'b0000, 0, 1, 2'd3, 8'd200, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 0, 3'd0));
    arm_on();
    put(8'h07);
    chk("R5 value 7 moves to state 1", state_o, 1);
    chk("R8 flag 1 set", flags_o, 4'b0010);
    put(8'h07);
    chk("R4 retry branch beats else", {state_o, flags_o}, {3'd1, 4'b0010});
    put(8'h03);
    chk("R4 else branch aborts", state_o, 0);
    chk("R8 set and clear in one branch", flags_o, 4'b0001);
    put(8'h07); put(8'h06);
    chk("R5 value 6 moves to state 2", {state_o, flags_o}, {3'd2, 4'b0111});
    put(8'h09);
    chk("R4 no branch true keeps state and flags", {state_o, flags_o}, {3'd2, 4'b0111});
    expect_trig(3'd2, 4'b0011, "R8 clear wins at value-5 trigger");
    put(8'h05);
    chk("R6 OR term fires on value", triggered_o, 1);
    arm_off();

    arm_on();
    wr(ba(0,0), br(4'b0000, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 1, 3'd5));
    put(8'h00);
    chk("R2 write while armed ignored", {triggered_o, state_o, flags_o}, 0);
    put(8'h07); put(8'h06);
    expect_trig(3'd2, 4'b0011, "R6 OR term fires on rising bit 7");
    put(8'h80);
    chk("R5 rising edge on bit 7 triggers", triggered_o, 1);
    arm_off();

    // Program C: AND, never mode, saturation, reset beats increment (R5, R6, R7)
    clear_all();
    wr(5'd0, cmpw(2'd1, 3'd0, 8'h01, 8'h01));
    wr(5'd1, cmpw(2'd1, 3'd0, 8'h02, 8'h02));
    wr(5'd2, cmpw(2'd0, 3'd0, 8'h00, 8'h00));
    wr(ba(0,0), br(4'b0011, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 3'd1));
    wr(ba(0,1), br(4'b0100, 0, 0, 2'd0, 8'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 3'd0));
    wr(ba(0,2), br(4'b0000, 0, 0, 2'd0, 8'd0, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0, 3'd0));
    wr(ba(1,0), br(4'b0000, 0, 1, 2'd1, 8'd255, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 1, 3'd1));
    wr(ba(1,1), br(4'b0001, 0, 0, 2'd0, 8'd0, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 0, 3'd1));
    wr(ba(1,2), br(4'b0000, 0, 0, 2'd0, 8'd0, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0, 3'd1));
    arm_on();
    put(8'h01);
    chk("R6 AND needs both bits (bit0 only)", state_o, 0);
    put(8'h02);
    chk("R6 AND needs both bits (bit1 only)", state_o, 0);
    for (int i = 0; i < 300; i++) put(8'h00);
    chk("R5 never mode does not fire", triggered_o, 0);
    put(8'h03);
    chk("R6 AND of both bits moves to state 1", state_o, 1);
    expect_trig(3'd1, 4'b1000, "R7 saturated counter equals 255");
    put(8'h00);
    chk("R7 counter saturated at 255", triggered_o, 1);
    arm_off();

    arm_on();
    put(8'h03);
    chk("R3 counters cleared on re-arm", {state_o, triggered_o}, {3'd1, 1'b0});
    for (int i = 0; i < 254; i++) put(8'h00);
    put(8'h01);
    chk("R7 reset beats increment", triggered_o, 0);
    for (int i = 0; i < 255; i++) put(8'h00);
    chk("R7 count from zero not yet 255", triggered_o, 0);
    expect_trig(3'd1, 4'b1000, "R7 trigger after 255 increments");
    put(8'h00);
    chk("R7 fires when count reaches 255", triggered_o, 1);
    arm_off();

    repeat (3) @(negedge clk);
    chk("R9 all expected triggers seen", sb_q.size(), 0);
    report();
  end

endmodule